// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Core

This block is the digital front end of a two-channel digital-to-analog converter. A host writes frames over a three-wire serial link made of an active-low select, a data line and a serial clock. Each frame carries a two-bit channel address followed by a data word. When the select line rises, the address is decoded, and the data word goes into the staging register of channel A, of channel B, of both, or of neither. A level-sensitive, active-low load strobe copies both staging registers into the output code registers. Holding the strobe low makes every write show at the outputs directly. Holding it high lets the host stage both channels and then release them together. An active-low clear input forces every staging and output register to zero scale or to midscale, and a separate selection input chooses which.

All serial and control inputs are asynchronous to the block. Each one is brought into the system-clock domain through a two-stage synchronizer, and the edges of the serial clock and the select line are found by comparing the synchronized level with its value one cycle earlier. The system clock must run fast enough that every level of the serial clock lasts for at least two system-clock cycles. The data width is a parameter. The frame is always the data width plus two address bits, and midscale is the data word with only its top bit set.

Top module: `dual_dac_regs`

## Requirements
- R1: After the power-on reset `rst_n` is released, both `code_a` and `code_b` read zero.
- R2: A frame is shifted most significant bit first. Its top two bits are the address and its low DW bits are the data word. One bit is taken on each rising edge of `sclk` while `cs_n` is low.
- R3: When more than DW+2 bits are shifted during one select period, only the last DW+2 bits are decoded, and the earlier ones are ignored.
- R4: On the rising edge of `cs_n`, address 01 writes the data word into channel A's staging register only, and address 10 writes it into channel B's staging register only.
- R5: Address 00 changes neither staging register.
- R6: Address 11 writes the same data word into both staging registers.
- R7: While `load_n` is low, each output code follows its staging register one system clock later. While `load_n` is high, both output codes hold. The rising edge of `load_n` changes nothing.
- R8: While `clr_n` is low, all four registers are forced to zero when `mid_sel` is 0, or to midscale (only the top data bit set) when `mid_sel` is 1. This applies whatever the state of `load_n`, and it takes priority over a select-line rising edge that arrives at the same time.
- R9: Rising edges of `sclk` while `cs_n` is high do not alter the shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sclk | input | 1 | Serial clock; shifts on its rising edge |
| cs_n | input | 1 | Serial select, active low; its rising edge commits a frame |
| sdi | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Output load strobe, level sensitive, active low |
| clr_n | input | 1 | Dynamic clear, active low |
| mid_sel | input | 1 | Clear value select: 0 gives zero scale, 1 gives midscale |
| code_a | output | DW | Channel A output code |
| code_b | output | DW | Channel B output code |

## Verification
On every cycle, the assertions check the following: the hold and follow behaviour of the output codes under the synchronized load strobe, the forced clear value together with its priority, staging registers that change only on a decoded select edge, channel B left alone by a channel-A write, and equal staging contents after a broadcast. Other behaviour can only be shown by the bench's scenarios with their expected codes. These cover the order of bits within a frame, the discarding of leading surplus bits, serial clocks that arrive while the block is deselected, and two staged channels released together by one strobe. A behavioural model in the bench also follows every cycle, including the synchronizer latency.

// File: rtl/dual_dac_regs.sv
module dual_dac_regs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  input  logic          load_n,
  input  logic          clr_n,
  input  logic          mid_sel,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b
);
  localparam int FW = DW + 2;
  localparam int NS = 6;
  // synchronized vector: {mid_sel, clr_n, load_n, sdi, cs_n, sclk}
  localparam logic [NS-1:0] IDLE = 6'b011010;
  localparam logic [DW-1:0] MIDV = {1'b1, {(DW-1){1'b0}}};

  logic [NS-1:0] m1, m2;
  logic [1:0]    prv;
  logic [FW-1:0] sh;
  logic [DW-1:0] in_a, in_b;

  logic sclk_s, cs_s, sdi_s, ld_s, clr_s, mid_s;
  logic shift_en, cs_rise;
  logic [1:0]    addr;
  logic [DW-1:0] preset;

  assign sclk_s   = m2[0];
  assign cs_s     = m2[1];
  assign sdi_s    = m2[2];
  assign ld_s     = m2[3];
  assign clr_s    = m2[4];
  assign mid_s    = m2[5];
  assign shift_en = sclk_s & ~prv[0] & ~cs_s;
  assign cs_rise  = cs_s & ~prv[1];
  assign addr     = sh[FW-1:FW-2];
  assign preset   = mid_s ? MIDV : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1  <= IDLE;
      m2  <= IDLE;
      prv <= 2'b10;
    end else begin
      m1  <= {mid_sel, clr_n, load_n, sdi, cs_n, sclk};
      m2  <= m1;
      prv <= {cs_s, sclk_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (shift_en) sh <= {sh[FW-2:0], sdi_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_a <= '0;
      in_b <= '0;
    end else if (!clr_s) begin
      in_a <= preset;
      in_b <= preset;
    end else if (cs_rise) begin
      if (addr[0]) in_a <= sh[DW-1:0];
      if (addr[1]) in_b <= sh[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a <= '0;
      code_b <= '0;
    end else if (!clr_s) begin
      code_a <= preset;
      code_b <= preset;
    end else if (!ld_s) begin
      code_a <= in_a;
      code_b <= in_b;
    end
  end
endmodule

// File: rtl/dual_dac_regs_chk.sv
module dual_dac_regs_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_s,
  input logic          clr_s,
  input logic          mid_s,
  input logic          cs_rise,
  input logic [1:0]    addr,
  input logic [DW-1:0] in_a,
  input logic [DW-1:0] in_b,
  input logic [DW-1:0] code_a,
  input logic [DW-1:0] code_b
);
  localparam logic [DW-1:0] MIDV = {1'b1, {(DW-1){1'b0}}};

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s && clr_s) |=> ($stable(code_a) && $stable(code_b)));

  assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_s && clr_s) |=> (code_a == $past(in_a) && code_b == $past(in_b)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> (code_a == ($past(mid_s) ? MIDV : '0) && code_b == code_a
                && in_a == code_a && in_b == code_a));

  assert_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && !(cs_rise && addr != 2'b00)) |=> ($stable(in_a) && $stable(in_b)));

  assert_chan_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && cs_rise && addr == 2'b01) |=> $stable(in_b));

  assert_bcast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && cs_rise && addr == 2'b11) |=> (in_a == in_b));
endmodule

bind dual_dac_regs dual_dac_regs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_s(ld_s), .clr_s(clr_s), .mid_s(mid_s),
  .cs_rise(cs_rise), .addr(addr), .in_a(in_a), .in_b(in_b),
  .code_a(code_a), .code_b(code_b)
);

// File: tb/sim_dual_dac_regs.sv
`timescale 1ns/1ps
module sim_dual_dac_regs;
  localparam int DW = 16;
  localparam logic [5:0] IDLE = 6'b011010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, load_n = 1'b1, clr_n = 1'b1, mid_sel = 1'b0;
  logic [DW-1:0] code_a, code_b;

  int checks = 0, fails = 0;
  bit done = 0, reported = 0;

  always #5 clk = ~clk;

  dual_dac_regs #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .load_n(load_n), .clr_n(clr_n), .mid_sel(mid_sel),
    .code_a(code_a), .code_b(code_b)
  );

  // behavioural reference: two-cycle input latency, history kept in a queue
  logic [5:0] q[$] = '{IDLE, IDLE, IDLE};
  logic [DW+1:0] msh = '0;
  logic [DW-1:0] ma = '0, mb = '0, mca = '0, mcb = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q = '{IDLE, IDLE, IDLE};
      msh = '0; ma = '0; mb = '0; mca = '0; mcb = '0;
    end else begin
      logic [5:0] c, p;
      logic [DW-1:0] oa, ob, pre;
      q.push_back({mid_sel, clr_n, load_n, sdi, cs_n, sclk});
      if (q.size() > 4) void'(q.pop_front());
      c = q[1];
      p = q[0];
      pre = c[5] ? (1 << (DW - 1)) : 0;
      oa = ma;
      ob = mb;
      if (!c[4]) begin
        ma = pre; mb = pre; mca = pre; mcb = pre;
      end else begin
        if (c[1] && !p[1]) begin
          if (msh[DW]) ma = msh[DW-1:0];
          if (msh[DW+1]) mb = msh[DW-1:0];
        end
        if (!c[3]) begin
          mca = oa; mcb = ob;
        end
      end
      if (c[0] && !p[0] && !c[1]) msh = {msh[DW:0], c[2]};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (code_a !== mca || code_b !== mcb) begin
        fails++;
        $display("FAIL R7 per-cycle model: code_a=%h code_b=%h expected %h %h",
                 code_a, code_b, mca, mcb);
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      sclk = 1'b0; wclk(3);
      sclk = 1'b1; wclk(3);
    end
    sclk = 1'b0; wclk(3);
  endtask

  task automatic frame(input logic [31:0] bits, input int n);
    cs_n = 1'b0; wclk(3);
    shift_bits(bits, n);
    cs_n = 1'b1; wclk(8);
  endtask

  task automatic chk(input string req, input logic [DW-1:0] ea, input logic [DW-1:0] eb);
    checks++;
    if (code_a !== ea || code_b !== eb) begin
      fails++;
      $display("FAIL %s: code_a=%h code_b=%h expected %h %h", req, code_a, code_b, ea, eb);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      done = 1;
      finish_run();
    end
  end

  initial begin
    wclk(4);
    rst_n = 1'b1;
    wclk(6);
    chk("R1 reset state", 16'h0000, 16'h0000);

    load_n = 1'b0; wclk(4);
    frame({2'b01, 16'h1234}, 18);
    chk("R4 write A only", 16'h1234, 16'h0000);
    frame({2'b10, 16'hBEEF}, 18);
    chk("R4 write B only", 16'h1234, 16'hBEEF);
    frame({2'b00, 16'hFFFF}, 18);
    chk("R5 address 00 no change", 16'h1234, 16'hBEEF);
    frame({2'b11, 16'h5A5A}, 18);
    chk("R6 broadcast", 16'h5A5A, 16'h5A5A);
    frame({2'b01, 16'h8001}, 18);
    chk("R2 msb-first order", 16'h8001, 16'h5A5A);
    frame({6'b111111, 2'b01, 16'h0F0F}, 24);
    chk("R3 24-bit frame keeps last 18", 16'h0F0F, 16'h5A5A);

    // R9: clocks with select high must not disturb the shift register
    shift_bits({2'b11, 16'h0000}, 18);
    cs_n = 1'b0; wclk(4); cs_n = 1'b1; wclk(8);
    chk("R9 no shift while deselected", 16'h0F0F, 16'h5A5A);

    load_n = 1'b1; wclk(4);
    frame({2'b01, 16'h7777}, 18);
    chk("R7 hold while strobe high", 16'h0F0F, 16'h5A5A);
    load_n = 1'b0; wclk(6);
    chk("R7 transparent while strobe low", 16'h7777, 16'h5A5A);
    load_n = 1'b1; wclk(4);
    frame({2'b01, 16'h4444}, 18);
    frame({2'b10, 16'h3333}, 18);
    chk("R7 both staged, outputs held", 16'h7777, 16'h5A5A);
    load_n = 1'b0; wclk(4); load_n = 1'b1; wclk(8);
    chk("R7 simultaneous update, rising edge inert", 16'h4444, 16'h3333);

    mid_sel = 1'b1; clr_n = 1'b0; wclk(6);
    chk("R8 midscale clear with strobe high", 16'h8000, 16'h8000);
    clr_n = 1'b1; wclk(4);
    load_n = 1'b0; wclk(6);
    chk("R8 staging registers cleared to midscale", 16'h8000, 16'h8000);
    mid_sel = 1'b0; clr_n = 1'b0; wclk(6);
    chk("R8 zero clear", 16'h0000, 16'h0000);
    clr_n = 1'b1; wclk(6);

    // R8 priority: select edge arrives while clear is held
    cs_n = 1'b0; wclk(3);
    shift_bits({2'b11, 16'h1111}, 18);
    clr_n = 1'b0; wclk(4);
    cs_n = 1'b1; wclk(8);
    clr_n = 1'b1; wclk(8);
    chk("R8 clear beats pending load", 16'h0000, 16'h0000);

    done = 1;
    wclk(2);
    finish_run();
  end
endmodule